// File: doc/BRIEF.md
# Prescaled Reloading Event Counter

This block keeps two counters that advance on a prescale tick, a single-cycle enable that arrives synchronous to the block clock. A down-counter steps toward zero on every tick. On a tick that finds it already at zero, it takes a fresh start value from a reload register, and the up-counter steps by one on that same tick. With a reload value of N, the up-counter therefore advances once every N+1 ticks in steady state. With a reload value of zero, the down-counter stays at zero and the up-counter advances on every tick.

Software can write the reload register and both counters at any time through three write strobes with data. It can observe both counters and the reload value on the outputs. A write never disturbs ticks that have already been counted. A reload write changes only reloads that happen on later ticks. When a write to a counter lands on a tick, the write decides that counter's next value. All state updates on the clock edge that samples the inputs.

Top module: `tick_reload_counter`

## Requirements
- R1: On a tick where the down-counter is non-zero and not being written, it decrements by one. The up-counter is unchanged unless it is written.
- R2: On a tick where the down-counter is zero and not being written, it takes the current reload value. On that same edge the up-counter increments by one unless it is written.
- R3: In steady state the up-counter advances once every reload+1 ticks. For example, with reload 5 and a start of 7, the down-counter runs 7,6,5,4,3,2,1,0,5,4,3,2,1,0,5 and the up-counter steps where 0 turns into 5.
- R4: With a reload value of zero, the down-counter stays at zero once it gets there, and the up-counter increments on every tick after that.
- R5: The down-counter may be written with a value larger than the reload value. The countdown then starts from the written value, and later periods use the reload value.
- R6: A reload write affects only later reloads. A tick that reloads on the same edge as a reload write uses the old reload value.
- R7: When a write to the down-counter or the up-counter coincides with a tick, the written value wins for that counter and the tick's effect on it is dropped. The other counter still follows the tick.
- R8: The up-counter wraps from all ones to zero with no other effect.
- R9: Reset clears the reload value, the down-counter and the up-counter to zero.
- R10: A cycle with no tick and no writes leaves all three values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Single-cycle prescale tick enable |
| reloadWrEn | input | 1 | Write strobe for the reload register |
| reloadWrData | input | CNT_W | Data for the reload register |
| downWrEn | input | 1 | Write strobe for the down-counter |
| downWrData | input | CNT_W | Data for the down-counter |
| upWrEn | input | 1 | Write strobe for the up-counter |
| upWrData | input | CNT_W | Data for the up-counter |
| reloadValue | output | CNT_W | Current reload value |
| downCount | output | CNT_W | Current down-counter value |
| upCount | output | CNT_W | Current up-counter value |

## Verification
The assertions assume that every input is a clean, known level at each sampling edge. They also assume that a write strobe applies only to the cycle in which it is high, so a tick and a write on the same edge are judged only by the priority rule. The stimulus changes inputs only on the falling edge and holds every strobe for exactly one cycle. It sweeps reload values 0 to 6 against start values 0 to 9, with ticks spaced by a bench parameter. Directed cases put writes on the same edge as a zero-crossing tick.

// File: rtl/tick_cnt_pkg.sv
package tick_cnt_pkg;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic loadReload;
    logic loadDown;
    logic decDown;
    logic reloadDown;
    logic loadUp;
    logic incUp;
  } cnt_strobe_t;

endpackage

// File: rtl/tick_cnt_ctrl.sv
module tick_cnt_ctrl
  import tick_cnt_pkg::*;
(
  input  logic        tickEn,
  input  logic        reloadWrEn,
  input  logic        downWrEn,
  input  logic        upWrEn,
  input  logic        downIsZero,
  output cnt_strobe_t strobes
);

  logic tickAtZero;
  logic tickAbove;

  always_comb begin
    tickAtZero = tickEn && downIsZero;
    tickAbove  = tickEn && !downIsZero;

    strobes            = '0;
    strobes.loadReload = reloadWrEn;
    // software write has priority over the tick for the same register
    strobes.loadDown   = downWrEn;
    strobes.decDown    = tickAbove && !downWrEn;
    strobes.reloadDown = tickAtZero && !downWrEn;
    strobes.loadUp     = upWrEn;
    strobes.incUp      = tickAtZero && !upWrEn;
  end

endmodule

// File: rtl/tick_cnt_dpath.sv
module tick_cnt_dpath
  import tick_cnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      strobes,
  input  logic [CNT_W-1:0] reloadWrData,
  input  logic [CNT_W-1:0] downWrData,
  input  logic [CNT_W-1:0] upWrData,
  output logic [CNT_W-1:0] reloadQ,
  output logic [CNT_W-1:0] downQ,
  output logic [CNT_W-1:0] upQ,
  output logic             downIsZero
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (strobes.loadReload) begin
      reloadQ <= reloadWrData;
    end
  end

  // the reload path reads the registered value, so a same-edge write is not seen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      downQ <= '0;
    end else if (strobes.loadDown) begin
      downQ <= downWrData;
    end else if (strobes.reloadDown) begin
      downQ <= reloadQ;
    end else if (strobes.decDown) begin
      downQ <= downQ - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ <= '0;
    end else if (strobes.loadUp) begin
      upQ <= upWrData;
    end else if (strobes.incUp) begin
      upQ <= upQ + ONE;
    end
  end

  assign downIsZero = (downQ == '0);

endmodule

// File: rtl/tick_reload_counter.sv
module tick_reload_counter
  import tick_cnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             reloadWrEn,
  input  logic [CNT_W-1:0] reloadWrData,
  input  logic             downWrEn,
  input  logic [CNT_W-1:0] downWrData,
  input  logic             upWrEn,
  input  logic [CNT_W-1:0] upWrData,
  output logic [CNT_W-1:0] reloadValue,
  output logic [CNT_W-1:0] downCount,
  output logic [CNT_W-1:0] upCount
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  cnt_strobe_t strobes;
  logic        downIsZero;

  tick_cnt_ctrl ctrl_i (
    .tickEn     (tickEn),
    .reloadWrEn (reloadWrEn),
    .downWrEn   (downWrEn),
    .upWrEn     (upWrEn),
    .downIsZero (downIsZero),
    .strobes    (strobes)
  );

  tick_cnt_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .reloadWrData (reloadWrData),
    .downWrData   (downWrData),
    .upWrData     (upWrData),
    .reloadQ      (reloadValue),
    .downQ        (downCount),
    .upQ          (upCount),
    .downIsZero   (downIsZero)
  );

  AST_DOWN_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !downWrEn && downCount != '0) |=> downCount == $past(downCount) - ONE); // R1

  AST_UP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!upWrEn && !(tickEn && downCount == '0)) |=> $stable(upCount)); // R1

  AST_RELOAD_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !downWrEn && downCount == '0) |=> downCount == $past(reloadValue)); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !upWrEn && downCount == '0) |=> upCount == $past(upCount) + ONE); // R2

  AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !reloadWrEn |=> $stable(reloadValue)); // R6

  AST_DOWN_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    downWrEn |=> downCount == $past(downWrData)); // R7

  AST_UP_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    upWrEn |=> upCount == $past(upWrData)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !downWrEn) |=> $stable(downCount)); // R10

endmodule

// File: tb/tick_reload_counter_tb_top.sv
module tick_reload_counter_tb_top;

  localparam int W = 32;
  parameter int TICK_DIV = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rstN = 1'b0;
  logic         tickEn = 1'b0;
  logic         reloadWrEn = 1'b0, downWrEn = 1'b0, upWrEn = 1'b0;
  logic [W-1:0] reloadWrData = '0, downWrData = '0, upWrData = '0;
  logic [W-1:0] reloadValue, downCount, upCount;

  tick_reload_counter #(.CNT_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .reloadWrEn(reloadWrEn), .reloadWrData(reloadWrData),
    .downWrEn(downWrEn), .downWrData(downWrData),
    .upWrEn(upWrEn), .upWrData(upWrData),
    .reloadValue(reloadValue), .downCount(downCount), .upCount(upCount)
  );

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] mRel = '0, mDown = '0, mUp = '0;

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(string req);
    check(req, "reload", reloadValue, mRel);
    check(req, "down", downCount, mDown);
    check(req, "up", upCount, mUp);
  endtask

  // called at a falling edge; drives one cycle, updates the model, compares
  task automatic step(string req, logic t, logic dw, logic [W-1:0] dd,
                      logic uw, logic [W-1:0] ud, logic pw, logic [W-1:0] pd);
    logic [W-1:0] nRel, nDown, nUp;
    tickEn = t; downWrEn = dw; downWrData = dd;
    upWrEn = uw; upWrData = ud; reloadWrEn = pw; reloadWrData = pd;
    @(posedge clk);
    nRel = mRel; nDown = mDown; nUp = mUp;
    if (t) begin
      if (mDown != '0) nDown = mDown - 1;
      else begin nDown = mRel; nUp = mUp + 1; end
    end
    if (dw) nDown = dd;
    if (uw) nUp = ud;
    if (pw) nRel = pd;
    mRel = nRel; mDown = nDown; mUp = nUp;
    @(negedge clk);
    tickEn = 1'b0; downWrEn = 1'b0; upWrEn = 1'b0; reloadWrEn = 1'b0;
    compareAll(req);
  endtask

  task automatic tickOnly(string req);
    step(req, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic idle(string req);
    step(req, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  function automatic logic [W-1:0] calcDown(int d, int p, int t);
    if (t <= d) return W'(d - t);
    return W'(p - ((t - d - 1) % (p + 1)));
  endfunction

  function automatic logic [W-1:0] calcUps(int d, int p, int t);
    if (t <= d) return '0;
    return W'(1 + (t - d - 1) / (p + 1));
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    compareAll("R9");
    idle("R10");

    // R3 and R5: reload 5, start at 7, literal sequence
    step("R5", 1'b0, 1'b1, W'(7), 1'b0, '0, 1'b1, W'(5));
    for (int i = 1; i <= 14; i++) begin
      tickOnly("R3");
      check("R3", "down seq", downCount, calcDown(7, 5, i));
      check("R3", "up seq", upCount, calcUps(7, 5, i));
      idle("R10");
    end
    check("R3", "two periods", upCount, W'(2));

    // sweep of reload against start values, ticks spaced by TICK_DIV
    for (int p = 0; p <= 6; p++) begin
      for (int d = 0; d <= 9; d++) begin
        step("R5", 1'b0, 1'b1, W'(d), 1'b1, '0, 1'b1, W'(p));
        for (int t = 1; t <= 2 * (p + 1) + d + 1; t++) begin
          tickOnly(p == 0 ? "R4" : "R2");
          for (int k = 1; k < TICK_DIV; k++) idle("R10");
          check(p == 0 ? "R4" : (d > p ? "R5" : "R3"), "sweep down", downCount, calcDown(d, p, t));
          check(p == 0 ? "R4" : (d > p ? "R5" : "R3"), "sweep up", upCount, calcUps(d, p, t));
        end
      end
    end

    // R7: down write on a zero-crossing tick; up still increments
    step("R7", 1'b0, 1'b1, '0, 1'b1, W'(10), 1'b1, W'(4));
    step("R7", 1'b1, 1'b1, W'(9), 1'b0, '0, 1'b0, '0);
    check("R7", "down write wins", downCount, W'(9));
    check("R7", "up follows tick", upCount, W'(11));
    // R7: up write on a zero-crossing tick; down still reloads
    step("R7", 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, '0);
    step("R7", 1'b1, 1'b0, '0, 1'b1, W'(256), 1'b0, '0);
    check("R7", "up write wins", upCount, W'(256));
    check("R7", "down follows tick", downCount, W'(4));
    // R1: tick above zero together with an up write
    step("R7", 1'b1, 1'b0, '0, 1'b1, W'(3), 1'b0, '0);
    check("R1", "down decrements", downCount, W'(3));
    check("R7", "up write on dec tick", upCount, W'(3));

    // R6: reload write on the same edge as a reload uses the old value
    step("R6", 1'b0, 1'b1, '0, 1'b1, '0, 1'b1, W'(3));
    step("R6", 1'b1, 1'b0, '0, 1'b0, '0, 1'b1, W'(8));
    check("R6", "old reload used", downCount, W'(3));
    check("R6", "new reload stored", reloadValue, W'(8));
    tickOnly("R6"); tickOnly("R6"); tickOnly("R6");
    check("R6", "reached zero", downCount, '0);
    tickOnly("R6");
    check("R6", "later reload new", downCount, W'(8));
    check("R6", "up count", upCount, W'(2));

    // R8: wrap of the up-counter
    step("R8", 1'b0, 1'b1, '0, 1'b1, '1, 1'b1, W'(2));
    tickOnly("R8");
    check("R8", "wrap", upCount, '0);
    check("R8", "reload after wrap", downCount, W'(2));

    // R10: idle cycles hold everything
    for (int i = 0; i < 5; i++) idle("R10");
    check("R10", "hold down", downCount, W'(2));

    summary();
  end

endmodule